// File: doc/BRIEF.md
# Opcode-Selected Register-Operation Controller

This block sequences the control actions of a small two-register unit (registers p and q) through one of three operations: doubling, addition and exchange. A one-hot select bus picks the operation. Six actions share one request/acknowledge pair each: decode, load p, load q, add into p, store p and store q. Each action is held once and is shared by all three operations. Every precedence arc between two actions carries a condition on the select bits, so one precedence network produces three different event orders.

A run begins when `start_i` is seen high while the block is idle; the select code is captured at that moment. Requests rise in the order that the captured operation allows and stay high until the run ends. `done_o` rises once the final stores have been acknowledged. The environment then lowers `start_i`. All requests and `done_o` drop, and the block waits for every acknowledge to return low before it accepts a new start. Only actions on a path to completion are ever requested.

Top module: `opsel_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `req_o` is all zero and `done_o` is low.
- R2: When `start_i` is sampled high at a rising edge while idle, the decode request (`req_o[0]`) is high after the second rising edge counted from that one.
- R3: With select 3'b001 (doubling, bit 0), load p (bit 1), add (bit 3) and store p (bit 4) are each requested one cycle after the acknowledge of decode, load p and add respectively. Load q (bit 2) and store q (bit 5) are never requested.
- R4: With select 3'b010 (addition, bit 1), load p and load q are requested in the same cycle, one cycle after the decode acknowledge. Add is requested one cycle after the later of the two load acknowledges. Store q is never requested.
- R5: With select 3'b100 (exchange, bit 2), store p and store q are requested in the same cycle, one cycle after the later of the two load acknowledges. Add is never requested.
- R6: Once a request is raised, it stays high for as long as `start_i` stays high.
- R7: `done_o` rises exactly one cycle after the last needed store acknowledge is high. That is store p alone for doubling and addition, and both stores for exchange.
- R8: If `start_i` is low while `done_o` is high, all requests and `done_o` are low after the next rising edge. A start seen while any acknowledge is still high is ignored.
- R9: The select code is captured only at the start of a run; changing `sel_i` during a run has no effect on the order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a run when high at idle; lowering it after done ends the run |
| sel_i | input | 3 | One-hot operation select: bit 0 doubling, bit 1 addition, bit 2 exchange |
| ack_i | input | 6 | Acknowledges: 0 decode, 1 load p, 2 load q, 3 add, 4 store p, 5 store q |
| req_o | output | 6 | Requests, same bit order as `ack_i` |
| done_o | output | 1 | All needed actions acknowledged |

## Verification
A wrong captured operation or a wrong arc condition shows at the ports one cycle after the acknowledge that should release a request. The request either rises early, rises late, or rises for an action that does not belong to the operation. Because the bench model predicts every request bit on every cycle, any such fault is reported in the cycle it first appears. A phase register stuck in the wrong state shows either as requests that fail to drop one cycle after start falls, or as a run that begins while acknowledges are still high.

// File: rtl/opsel_pkg.sv
package opsel_pkg;

    localparam int N_ACT = 6;
    localparam int N_OP  = 3;

    localparam int A_DEC = 0;
    localparam int A_LDP = 1;
    localparam int A_LDQ = 2;
    localparam int A_ADD = 3;
    localparam int A_STP = 4;
    localparam int A_STQ = 5;

    localparam int O_DBL = 0;
    localparam int O_SUM = 1;
    localparam int O_XCH = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_RET  = 2'd2
    } phase_e;

    typedef logic [N_ACT-1:0] act_vec_t;
    typedef logic [N_OP-1:0]  op_vec_t;

    // Condition of the precedence arc from action j to action k.
    function automatic logic arc_on(input op_vec_t s, input int j, input int k);
        logic r;
        r = 1'b0;
        if (j == A_DEC && k == A_LDP) r = 1'b1;
        if (j == A_DEC && k == A_LDQ) r = 1'b1;
        if (j == A_LDP && k == A_ADD) r = s[O_DBL] | s[O_SUM];
        if (j == A_LDQ && k == A_ADD) r = s[O_SUM];
        if (j == A_ADD && k == A_STP) r = s[O_DBL] | s[O_SUM];
        if ((j == A_LDP || j == A_LDQ) && (k == A_STP || k == A_STQ)) r = s[O_XCH];
        return r;
    endfunction

    // Condition of the arc from action j into completion.
    function automatic logic done_arc(input op_vec_t s, input int j);
        logic r;
        r = 1'b0;
        if (j == A_STP) r = 1'b1;
        if (j == A_STQ) r = s[O_XCH];
        return r;
    endfunction

    // Actions with a path to completion under the given select.
    function automatic act_vec_t member_mask(input op_vec_t s);
        act_vec_t m;
        for (int j = 0; j < N_ACT; j++) m[j] = done_arc(s, j);
        for (int it = 0; it < N_ACT; it++)
            for (int k = 0; k < N_ACT; k++)
                for (int j = 0; j < N_ACT; j++)
                    if (m[k] && arc_on(s, j, k)) m[j] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/opsel_phase.sv
module opsel_phase
    import opsel_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  op_vec_t sel_i,
    input  logic    done_q,
    input  logic    ack_any,
    output phase_e  phase,
    output op_vec_t op_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            op_q  <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start_i && !ack_any) begin
                    op_q  <= sel_i;
                    phase <= PH_RUN;
                end
                PH_RUN:  if (done_q && !start_i) phase <= PH_RET;
                PH_RET:  if (!ack_any) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/opsel_gate.sv
module opsel_gate
    import opsel_pkg::*;
#(
    parameter int IDX = 0
) (
    input  op_vec_t  op,
    input  act_vec_t ack,
    output logic     ready
);
    act_vec_t mem;
    always_comb begin
        mem   = member_mask(op);
        ready = mem[IDX];
        for (int j = 0; j < N_ACT; j++)
            if (arc_on(op, j, IDX) && !ack[j]) ready = 1'b0;
    end
endmodule

// File: rtl/opsel_done.sv
module opsel_done
    import opsel_pkg::*;
(
    input  op_vec_t  op,
    input  act_vec_t ack,
    output logic     ready
);
    always_comb begin
        ready = 1'b1;
        for (int j = 0; j < N_ACT; j++)
            if (done_arc(op, j) && !ack[j]) ready = 1'b0;
    end
endmodule

// File: rtl/opsel_ctrl.sv
module opsel_ctrl
    import opsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [N_OP-1:0]  sel_i,
    input  logic [N_ACT-1:0] ack_i,
    output logic [N_ACT-1:0] req_o,
    output logic             done_o
);
    phase_e   phase;
    op_vec_t  op_q;
    act_vec_t ready;
    act_vec_t req_q;
    logic     done_q;
    logic     done_rdy;
    logic     ack_any;

    assign ack_any = |ack_i;

    opsel_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .sel_i   (sel_i),
        .done_q  (done_q),
        .ack_any (ack_any),
        .phase   (phase),
        .op_q    (op_q)
    );

    for (genvar g = 0; g < N_ACT; g++) begin : g_act
        opsel_gate #(.IDX(g)) u_gate (
            .op    (op_q),
            .ack   (ack_i),
            .ready (ready[g])
        );
    end

    opsel_done u_done (
        .op    (op_q),
        .ack   (ack_i),
        .ready (done_rdy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            done_q <= 1'b0;
        end else if (phase == PH_RUN && !(done_q && !start_i)) begin
            req_q  <= req_q | ready;
            done_q <= done_rdy;
        end else begin
            req_q  <= '0;
            done_q <= 1'b0;
        end
    end

    assign req_o  = req_q;
    assign done_o = done_q;
endmodule

// File: rtl/opsel_ctrl_chk.sv
module opsel_ctrl_chk
    import opsel_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [N_ACT-1:0] ack_i,
    input logic [N_ACT-1:0] req_o,
    input logic             done_o,
    input logic [N_OP-1:0]  op_q
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (req_o == '0 && !done_o));

    a_r3_double_no_q: assert property (@(posedge clk) disable iff (rst)
        op_q == 3'b001 |-> (!req_o[A_LDQ] && !req_o[A_STQ]));

    a_r4_add_after_loads: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o[A_ADD]) |-> ($past(ack_i[A_LDP]) && (!op_q[O_SUM] || $past(ack_i[A_LDQ]))));

    a_r5_exchange_no_add: assert property (@(posedge clk) disable iff (rst)
        op_q == 3'b100 |-> !req_o[A_ADD]);

    a_r5_stores_paired: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_o[A_STP]) && op_q[O_XCH]) |-> req_o[A_STQ]);

    for (genvar k = 0; k < N_ACT; k++) begin : g_hold
        a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
            (req_o[k] && start_i) |=> req_o[k]);
    end

    a_r7_done_after_stores: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($past(ack_i[A_STP]) && (!op_q[O_XCH] || $past(ack_i[A_STQ]))));

    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (req_o == '0 && !done_o));
endmodule

bind opsel_ctrl opsel_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .ack_i   (ack_i),
    .req_o   (req_o),
    .done_o  (done_o),
    .op_q    (op_q)
);

// File: tb/opsel_ctrl_bench.sv
`timescale 1ns/1ps
module opsel_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] sel = 3'b001;
    logic [5:0] ack = '0;
    logic [5:0] req;
    logic       done;

    always #2 clk = ~clk;

    opsel_ctrl u_opsel_ctrl (
        .clk(clk), .rst(rst), .start_i(start), .sel_i(sel),
        .ack_i(ack), .req_o(req), .done_o(done)
    );

    int n_run = 0, n_fail = 0, cyc = 0;
    int up_d[6], dn_d[6], cnt[6], ack_t[6], req_t[6];
    int done_t;
    bit req_fell;
    logic [5:0] prev_req = '0;

    // reference model state
    int         m_ph = 0;
    logic [2:0] m_op = '0;
    logic [5:0] m_req = '0;
    logic       m_done = 1'b0;

    function automatic logic [5:0] preds(input logic [2:0] op, input int k);
        logic [5:0] p = '0;
        case (op)
            3'b001: case (k) 1: p = 6'b000001; 3: p = 6'b000010; 4: p = 6'b001000; default: p = '0; endcase
            3'b010: case (k) 1, 2: p = 6'b000001; 3: p = 6'b000110; 4: p = 6'b001000; default: p = '0; endcase
            3'b100: case (k) 1, 2: p = 6'b000001; 4, 5: p = 6'b000110; default: p = '0; endcase
            default: p = '0;
        endcase
        return p;
    endfunction

    function automatic logic [5:0] used(input logic [2:0] op);
        case (op)
            3'b001:  return 6'b011011;
            3'b010:  return 6'b011111;
            3'b100:  return 6'b110111;
            default: return 6'b000000;
        endcase
    endfunction

    function automatic logic [5:0] finals(input logic [2:0] op);
        return (op == 3'b100) ? 6'b110000 : 6'b010000;
    endfunction

    always @(posedge clk) begin
        logic [5:0] nr, u;
        cyc++;
        if (rst) begin
            m_ph = 0; m_op = '0; m_req = '0; m_done = 1'b0;
        end else begin
            case (m_ph)
                0: if (start && ack == 0) begin m_op = sel; m_ph = 1; end
                1: if (m_done && !start) begin
                        m_ph = 2; m_req = '0; m_done = 1'b0;
                   end else begin
                        nr = m_req;
                        u = used(m_op);
                        for (int k = 0; k < 6; k++)
                            if (u[k] && ((preds(m_op, k) & ~ack) == 0)) nr[k] = 1'b1;
                        m_done = ((finals(m_op) & ~ack) == 0);
                        m_req = nr;
                   end
                default: if (ack == 0) m_ph = 0;
            endcase
        end
    end

    // compare, record and respond on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            n_run++;
            if (req !== m_req || done !== m_done) begin
                n_fail++;
                $display("FAIL R6 R7 cycle %0d: req=%b done=%b expected req=%b done=%b",
                         cyc, req, done, m_req, m_done);
            end
            for (int k = 0; k < 6; k++) begin
                if (req[k] && req_t[k] < 0) req_t[k] = cyc;
                if (!req[k] && prev_req[k] && start) req_fell = 1'b1;
                if (req[k] && !ack[k]) begin
                    cnt[k]++;
                    if (cnt[k] >= up_d[k]) begin ack[k] = 1'b1; ack_t[k] = cyc; cnt[k] = 0; end
                end else if (!req[k] && ack[k]) begin
                    cnt[k]++;
                    if (cnt[k] >= dn_d[k]) begin ack[k] = 1'b0; cnt[k] = 0; end
                end
            end
            if (done && done_t < 0) done_t = cyc;
            prev_req = req;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic run_op(input logic [2:0] s, input int seed, input bit flip);
        int cs, last;
        for (int k = 0; k < 6; k++) begin
            up_d[k] = ((k * 3 + seed) % 4) + 1;
            dn_d[k] = 3 + ((k + seed) % 3);
            cnt[k] = 0; req_t[k] = -1; ack_t[k] = -1;
        end
        done_t = -1; req_fell = 1'b0;
        @(negedge clk); #1;
        sel = s; start = 1'b1; cs = cyc;
        if (flip) begin @(negedge clk); #1; sel = 3'b001; end
        for (int i = 0; i < 300 && !done; i++) begin @(negedge clk); #1; end
        chk(done, "R7 done reached", done, 1);
        chk(req_t[0] == cs + 2, "R2 decode request cycle", req_t[0], cs + 2);
        last = (s == 3'b100) ? mx(ack_t[4], ack_t[5]) : ack_t[4];
        chk(done_t == last + 1, "R7 done timing", done_t, last + 1);
        chk(!req_fell, "R6 request held", req_fell, 0);
        if (s == 3'b001) begin
            chk(req_t[1] == ack_t[0] + 1, "R3 load p after decode", req_t[1], ack_t[0] + 1);
            chk(req_t[3] == ack_t[1] + 1, "R3 add after load p", req_t[3], ack_t[1] + 1);
            chk(req_t[4] == ack_t[3] + 1, "R3 store p after add", req_t[4], ack_t[3] + 1);
            chk(req_t[2] == -1 && req_t[5] == -1, "R3 no q actions", req_t[2] + req_t[5], -2);
        end else if (s == 3'b010) begin
            chk(req_t[1] == req_t[2], "R4 loads together", req_t[2], req_t[1]);
            chk(req_t[1] == ack_t[0] + 1, "R4 loads after decode", req_t[1], ack_t[0] + 1);
            chk(req_t[3] == mx(ack_t[1], ack_t[2]) + 1, "R4 add after both loads",
                req_t[3], mx(ack_t[1], ack_t[2]) + 1);
            chk(req_t[5] == -1, "R4 no store q", req_t[5], -1);
        end else begin
            chk(req_t[4] == req_t[5], flip ? "R9 R5 stores together" : "R5 stores together",
                req_t[5], req_t[4]);
            chk(req_t[4] == mx(ack_t[1], ack_t[2]) + 1, flip ? "R9 R5 stores after loads" : "R5 stores after loads",
                req_t[4], mx(ack_t[1], ack_t[2]) + 1);
            chk(req_t[3] == -1, flip ? "R9 R5 no add" : "R5 no add", req_t[3], -1);
        end
        start = 1'b0;
        @(negedge clk); #1;
        chk(req == 0 && !done, "R8 release", {25'd0, done, req}, 0);
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        for (int i = 0; i < 50 && ack != 0; i++) begin @(negedge clk); #1; end
        repeat (3) @(negedge clk);
        #1;
        chk(req == 0 && !done, "R8 start during return ignored", {25'd0, done, req}, 0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog: run hung at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        for (int k = 0; k < 6; k++) begin
            up_d[k] = 1; dn_d[k] = 3; cnt[k] = 0; ack_t[k] = -1; req_t[k] = -1;
        end
        done_t = -1;
        repeat (3) @(negedge clk);
        #1;
        chk(req == 0 && !done, "R1 outputs in reset", {25'd0, done, req}, 0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(req == 0 && !done, "R1 outputs after reset", {25'd0, done, req}, 0);
        run_op(3'b001, 0, 1'b0);
        run_op(3'b010, 0, 1'b0);
        run_op(3'b100, 1, 1'b0);
        run_op(3'b001, 2, 1'b0);
        run_op(3'b010, 3, 1'b0);
        run_op(3'b100, 2, 1'b0);
        run_op(3'b100, 3, 1'b1);
        finish_run();
    end
endmodule